// File: doc/BRIEF.md
# SEC-DED Write-Path Encoder

This block sits in front of a memory data path. For every accepted write word it computes single-error-correct, double-error-detect check bits and presents the data together with a check-bit byte lane. When a beat carries two codewords, as a double-data-rate memory needs, each half of the beat is encoded independently and gets its own eight-bit check lane.

A build option places a byte-merge stage in front of the encoder. That stage combines new write bytes with previously read bytes under a byte enable, which is how a partial write becomes a read-modify-write. A tracker counts accepted beats in groups of four and, at the end of each group, reports whether that burst needs a read-modify-write.

For testing the decode side downstream, a second build option adds an error-injection stage. It can flip one or two chosen bits of the outgoing codewords. When that option is off the stage is not built and the codewords leave untouched. Input and output use valid/ready handshakes, and the output holds steady while the consumer stalls.

Top module: `wr_ecc_encoder`

## Requirements
- R1: With Hamming bit count h (smallest h with 2^h >= DW+h+1), each codeword has h+1 check bits: 5, 6, 7 and 8 for DW = 8, 16, 32 and 64. Codeword positions start at 1. Data bit i takes the i-th position that is not a power of two, and Hamming bit j is the XOR of the data bits whose position has bit j set. Check bit h is the XOR of all data bits and all Hamming bits.
- R2: Codeword k puts its check bits on out_chk[8k +: CB]. The bits of each lane above CB are always zero.
- R3: With DUAL=1 each beat holds two codewords, codeword k on out_data[k*DW +: DW], each with its own check bits. With DUAL=0 there is one codeword.
- R4: inj_mode encodes 0 = off, 1 = flip the bit at inj_idx_a, 2 = flip the bits at inj_idx_a and inj_idx_b, 3 = off. The flip index is k*CW + i, where CW = DW+CB. An offset i below DW selects data bit i and i >= DW selects check bit i-DW. An index at or above NINST*CW flips nothing, and equal indices in mode 2 flip one bit.
- R5: With INJ_EN=0 the outputs are the unmodified codewords, whatever the injection inputs hold.
- R6: With RMW_EN=1, byte b of the word that gets encoded is in_data when in_be[b]=1 and in_old when it is 0. With RMW_EN=0, in_be and in_old have no effect.
- R7: A word accepted at a rising edge appears on out_valid/out_data/out_chk after the second edge counting the accepting edge when RMW_EN=1, and after the accepting edge itself when RMW_EN=0. Data and its check bits appear together, and words leave in the order they arrived.
- R8: While out_valid=1 and out_ready=0 the outputs stay stable. in_ready is low only while the output holds a word that is stalled.
- R9: Accepted beats are counted in bursts of 4 from reset. After the edge that accepts the 4th beat, burst_flag_valid is high for one cycle, with burst_rmw=1 if any in_be bit was 0 in any beat of that burst and 0 otherwise.
- R10: After reset out_valid=0, burst_flag_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Write word accepted when high with in_valid |
| in_data | input | NINST*DW | New write data |
| in_be | input | NINST*DW/8 | Byte enables, 1 = take new byte |
| in_old | input | NINST*DW | Previously read data for merge |
| inj_mode | input | 2 | Injection mode: 0 off, 1 single, 2 double, 3 off |
| inj_idx_a | input | IDXW | First flip index |
| inj_idx_b | input | IDXW | Second flip index |
| out_valid | output | 1 | Encoded word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | NINST*DW | Data part of the codewords |
| out_chk | output | 8*NINST | Check-bit lanes, one byte per codeword |
| burst_flag_valid | output | 1 | One-cycle pulse at the end of each 4-beat burst |
| burst_rmw | output | 1 | Burst needs read-modify-write |

## Verification
On every cycle the assertions check that a stalled output holds its data and check lanes, that the unused lane bits stay zero, that in_ready falls only under a stalled output, that with the merge stage every accepted word fills that stage, and that the burst flag appears only right after an accepted beat and lasts one cycle. The code itself is checked only by the bench's scenarios. The bench decodes each lane with its own syndrome model and confirms a clean result with injection off, a correctable syndrome at the injected position for one flip, and a double-error signature for two flips. The merge result, the exact latency, the order of words after a stall, the burst flag value and the build without injection are also shown only by the scenarios.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    INJ_OFF  = 2'd0,
    INJ_ONE  = 2'd1,
    INJ_TWO  = 2'd2,
    INJ_RSVD = 2'd3
  } inj_mode_e;

  // Hamming bits needed to cover dw data bits.
  function automatic int hamming_bits(input int dw);
    for (int r = 1; r < 16; r++)
      if ((1 << r) >= dw + r + 1) return r;
    return 16;
  endfunction

  // Hamming bits plus one overall parity bit.
  function automatic int check_bits(input int dw);
    return hamming_bits(dw) + 1;
  endfunction

endpackage

// File: rtl/secded_merge_stage.sv
module secded_merge_stage #(
  parameter int BW     = 32,
  parameter bit RMW_EN = 1'b1,
  localparam int NBYTE = BW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BW-1:0]    in_data,
  input  logic [NBYTE-1:0] in_be,
  input  logic [BW-1:0]    in_old,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BW-1:0]    out_data
);

  function automatic logic [BW-1:0] merge_bytes(input logic [BW-1:0] nw,
                                                input logic [BW-1:0] od,
                                                input logic [NBYTE-1:0] be);
    logic [BW-1:0] m;
    for (int b = 0; b < NBYTE; b++)
      m[8*b +: 8] = be[b] ? nw[8*b +: 8] : od[8*b +: 8];
    return m;
  endfunction

  generate
    if (RMW_EN) begin : g_merge
      logic          vq;
      logic [BW-1:0] dq;
      assign in_ready  = !vq || out_ready;
      assign out_valid = vq;
      assign out_data  = dq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vq <= 1'b0;
        else if (in_ready) vq <= in_valid;
      end
      always_ff @(posedge clk) begin
        if (in_valid && in_ready) dq <= merge_bytes(in_data, in_old, in_be);
      end
    end else begin : g_bypass
      logic unused_merge_inputs;
      assign unused_merge_inputs = ^{in_be, in_old, clk, rst_n};
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DW = 16,
  parameter int CB = 6,
  localparam int HB   = CB - 1,
  localparam int NPOS = DW + HB
) (
  input  logic [DW-1:0] data,
  output logic [CB-1:0] chk
);

  // Codeword position of data bit i: the i-th non-power-of-two.
  function automatic int data_pos(input int i);
    int p = 0;
    int n = -1;
    for (int q = 1; q <= NPOS; q++) begin
      if ((q & (q - 1)) != 0) begin
        n++;
        if (n == i) p = q;
      end
    end
    return p;
  endfunction

  function automatic logic [CB-1:0] encode(input logic [DW-1:0] d);
    logic [CB-1:0] c;
    int pos;
    c = '0;
    for (int i = 0; i < DW; i++) begin
      pos = data_pos(i);
      for (int j = 0; j < HB; j++)
        if (pos[j]) c[j] = c[j] ^ d[i];
    end
    c[HB] = ^{d, c[HB-1:0]};
    return c;
  endfunction

  assign chk = encode(data);

endmodule

// File: rtl/secded_inject.sv
module secded_inject #(
  parameter int W      = 44,
  parameter int IDXW   = 6,
  parameter bit INJ_EN = 1'b1
) (
  input  logic [W-1:0]    cw_in,
  input  logic [1:0]      mode,
  input  logic [IDXW-1:0] idx_a,
  input  logic [IDXW-1:0] idx_b,
  output logic [W-1:0]    cw_out
);
  import secded_pkg::*;

  function automatic logic [W-1:0] flip_mask(input logic [1:0] md,
                                             input logic [IDXW-1:0] a,
                                             input logic [IDXW-1:0] b);
    logic [W-1:0] m;
    logic use_a, use_b;
    use_a = (md == INJ_ONE) || (md == INJ_TWO);
    use_b = (md == INJ_TWO);
    for (int i = 0; i < W; i++)
      m[i] = (use_a && (32'(a) == i)) || (use_b && (32'(b) == i));
    return m;
  endfunction

  generate
    if (INJ_EN) begin : g_inj
      assign cw_out = cw_in ^ flip_mask(mode, idx_a, idx_b);
    end else begin : g_noinj
      logic unused_inj_inputs;
      assign unused_inj_inputs = ^{mode, idx_a, idx_b};
      assign cw_out = cw_in;
    end
  endgenerate

endmodule

// File: rtl/secded_burst_flag.sv
module secded_burst_flag #(
  parameter int NBYTE     = 4,
  parameter int BURST_LEN = 4,
  localparam int CNTW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic [NBYTE-1:0] beat_be,
  output logic             flag_valid,
  output logic             flag
);

  logic [CNTW-1:0] cnt;
  logic            partial_acc;
  logic            beat_partial;
  logic            last_beat;

  assign beat_partial = !(&beat_be);
  assign last_beat    = (cnt == CNTW'(BURST_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      partial_acc <= 1'b0;
      flag_valid  <= 1'b0;
      flag        <= 1'b0;
    end else begin
      flag_valid <= 1'b0;
      if (beat_fire) begin
        if (last_beat) begin
          cnt         <= '0;
          partial_acc <= 1'b0;
          flag_valid  <= 1'b1;
          flag        <= partial_acc || beat_partial;
        end else begin
          cnt         <= cnt + 1'b1;
          partial_acc <= partial_acc || beat_partial;
        end
      end
    end
  end

endmodule

// File: rtl/wr_ecc_encoder.sv
module wr_ecc_encoder #(
  parameter int DW        = 16,
  parameter bit DUAL      = 1'b1,
  parameter bit INJ_EN    = 1'b1,
  parameter bit RMW_EN    = 1'b1,
  parameter int BURST_LEN = 4,
  localparam int NINST = DUAL ? 2 : 1,
  localparam int BW    = NINST * DW,
  localparam int NBYTE = BW / 8,
  localparam int CB    = secded_pkg::check_bits(DW),
  localparam int CW    = DW + CB,
  localparam int FLATW = NINST * CW,
  localparam int IDXW  = $clog2(FLATW),
  localparam int CHW   = 8 * NINST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BW-1:0]    in_data,
  input  logic [NBYTE-1:0] in_be,
  input  logic [BW-1:0]    in_old,
  input  logic [1:0]       inj_mode,
  input  logic [IDXW-1:0]  inj_idx_a,
  input  logic [IDXW-1:0]  inj_idx_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BW-1:0]    out_data,
  output logic [CHW-1:0]   out_chk,
  output logic             burst_flag_valid,
  output logic             burst_rmw
);

  // Named internal events
  logic             in_fire;
  logic             m_valid;
  logic             m_ready;
  logic             m_fire;
  logic [BW-1:0]    m_data;
  logic [FLATW-1:0] enc_flat;
  logic [FLATW-1:0] inj_flat;
  logic             o_valid;
  logic [FLATW-1:0] o_flat;

  assign in_fire = in_valid && in_ready;
  assign m_fire  = m_valid && m_ready;
  assign m_ready = !o_valid || out_ready;

  secded_merge_stage #(.BW(BW), .RMW_EN(RMW_EN)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_be    (in_be),
    .in_old   (in_old),
    .out_valid(m_valid),
    .out_ready(m_ready),
    .out_data (m_data)
  );

  generate
    for (genvar k = 0; k < NINST; k++) begin : g_inst
      logic [CB-1:0] chk_k;
      secded_enc #(.DW(DW), .CB(CB)) u_enc (
        .data(m_data[k*DW +: DW]),
        .chk (chk_k)
      );
      assign enc_flat[k*CW +: CW] = {chk_k, m_data[k*DW +: DW]};
    end
  endgenerate

  secded_inject #(.W(FLATW), .IDXW(IDXW), .INJ_EN(INJ_EN)) u_inject (
    .cw_in (enc_flat),
    .mode  (inj_mode),
    .idx_a (inj_idx_a),
    .idx_b (inj_idx_b),
    .cw_out(inj_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_valid <= 1'b0;
    else if (m_ready) o_valid <= m_valid;
  end

  always_ff @(posedge clk) begin
    if (m_fire) o_flat <= inj_flat;
  end

  assign out_valid = o_valid;

  generate
    for (genvar k = 0; k < NINST; k++) begin : g_out
      assign out_data[k*DW +: DW] = o_flat[k*CW +: DW];
      assign out_chk[8*k +: CB]   = o_flat[k*CW + DW +: CB];
      if (CB < 8) begin : g_pad
        assign out_chk[8*k + CB +: 8 - CB] = '0;
      end
    end
  endgenerate

  secded_burst_flag #(.NBYTE(NBYTE), .BURST_LEN(BURST_LEN)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (in_fire),
    .beat_be   (in_be),
    .flag_valid(burst_flag_valid),
    .flag      (burst_rmw)
  );

endmodule

// File: rtl/wr_ecc_encoder_chk.sv
module wr_ecc_encoder_chk #(
  parameter int DW     = 16,
  parameter bit DUAL   = 1'b1,
  parameter bit RMW_EN = 1'b1,
  localparam int NINST = DUAL ? 2 : 1,
  localparam int BW    = NINST * DW,
  localparam int CB    = secded_pkg::check_bits(DW),
  localparam int CHW   = 8 * NINST
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           in_fire,
  input logic           m_valid,
  input logic           out_valid,
  input logic           out_ready,
  input logic [BW-1:0]  out_data,
  input logic [CHW-1:0] out_chk,
  input logic           burst_flag_valid
);

  function automatic logic [CHW-1:0] pad_mask();
    logic [CHW-1:0] m;
    for (int i = 0; i < CHW; i++) m[i] = ((i % 8) >= CB);
    return m;
  endfunction

  localparam logic [CHW-1:0] PAD_MASK = pad_mask();

  assert_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !burst_flag_valid && in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chk));

  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chk & PAD_MASK) == '0);

  assert_flag_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_flag_valid |-> $past(in_fire));

  assert_flag_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_flag_valid |=> !burst_flag_valid);

  generate
    if (RMW_EN) begin : g_rmw_chk
      assert_merge_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> m_valid);
    end
  endgenerate

endmodule

bind wr_ecc_encoder wr_ecc_encoder_chk #(.DW(DW), .DUAL(DUAL), .RMW_EN(RMW_EN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_ready        (in_ready),
  .in_fire         (in_fire),
  .m_valid         (m_valid),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_data        (out_data),
  .out_chk         (out_chk),
  .burst_flag_valid(burst_flag_valid)
);

// File: tb/wr_ecc_encoder_bench.sv
`timescale 1ns/1ps
module wr_ecc_encoder_bench;

  localparam int MDW = 16;
  localparam int MCW = 22;   // 16 data + 6 check
  localparam int LDW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int main_beats = 0;

  // main instance: DW=16, dual, injection, merge
  logic        m_in_valid = 1'b0;
  logic        m_in_ready;
  logic [31:0] m_in_data = '0;
  logic [3:0]  m_in_be = '1;
  logic [31:0] m_in_old = '0;
  logic [1:0]  m_inj_mode = 2'd0;
  logic [5:0]  m_idx_a = '0;
  logic [5:0]  m_idx_b = '0;
  logic        m_out_valid;
  logic        m_out_ready = 1'b1;
  logic [31:0] m_out_data;
  logic [15:0] m_out_chk;
  logic        m_flag_valid;
  logic        m_flag;

  // lite instance: DW=8, single, no injection, no merge
  logic       l_in_valid = 1'b0;
  logic       l_in_ready;
  logic [7:0] l_in_data = '0;
  logic [0:0] l_in_be = '1;
  logic [7:0] l_in_old = '0;
  logic [1:0] l_inj_mode = 2'd0;
  logic [3:0] l_idx_a = '0;
  logic [3:0] l_idx_b = '0;
  logic       l_out_valid;
  logic [7:0] l_out_data;
  logic [7:0] l_out_chk;
  logic       l_flag_valid;
  logic       l_flag;

  wr_ecc_encoder u_wr_ecc_encoder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(m_in_valid), .in_ready(m_in_ready),
    .in_data(m_in_data), .in_be(m_in_be), .in_old(m_in_old),
    .inj_mode(m_inj_mode), .inj_idx_a(m_idx_a), .inj_idx_b(m_idx_b),
    .out_valid(m_out_valid), .out_ready(m_out_ready),
    .out_data(m_out_data), .out_chk(m_out_chk),
    .burst_flag_valid(m_flag_valid), .burst_rmw(m_flag)
  );

  wr_ecc_encoder #(.DW(8), .DUAL(1'b0), .INJ_EN(1'b0), .RMW_EN(1'b0)) u_lite (
    .clk(clk), .rst_n(rst_n),
    .in_valid(l_in_valid), .in_ready(l_in_ready),
    .in_data(l_in_data), .in_be(l_in_be), .in_old(l_in_old),
    .inj_mode(l_inj_mode), .inj_idx_a(l_idx_a), .inj_idx_b(l_idx_b),
    .out_valid(l_out_valid), .out_ready(1'b1),
    .out_data(l_out_data), .out_chk(l_out_chk),
    .burst_flag_valid(l_flag_valid), .burst_rmw(l_flag)
  );

  // ---------------- reference model ----------------
  function automatic int ref_hb(input int dw);
    int r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  function automatic int ref_pos(input int i);
    int pos = 0;
    int k = 0;
    while (k <= i) begin
      pos++;
      if ((pos & (pos - 1)) != 0) k++;
    end
    return pos;
  endfunction

  // Hamming bits = XOR of positions of set data bits; top bit = overall parity.
  function automatic logic [7:0] ref_chk(input logic [63:0] d, input int dw);
    int hb = ref_hb(dw);
    int ham = 0;
    logic ovr = 1'b0;
    for (int i = 0; i < dw; i++)
      if (d[i]) begin
        ham = ham ^ ref_pos(i);
        ovr = ~ovr;
      end
    for (int j = 0; j < hb; j++) ovr = ovr ^ ham[j];
    return 8'(ham) | (8'(ovr) << hb);
  endfunction

  // 0 clean, 1 single (spos = syndrome position), 2 double
  function automatic int classify(input logic [63:0] d, input logic [7:0] c,
                                  input int dw, output int spos);
    int hb = ref_hb(dw);
    logic [7:0] rc = ref_chk(d, dw);
    int syn = 0;
    logic par = 1'b0;
    for (int j = 0; j < hb; j++) if (rc[j] != c[j]) syn = syn | (1 << j);
    for (int i = 0; i < dw; i++) par = par ^ d[i];
    for (int j = 0; j <= hb; j++) par = par ^ c[j];
    spos = syn;
    if (par) return 1;
    if (syn != 0) return 2;
    return 0;
  endfunction

  function automatic int flip_pos(input int off, input int dw);
    int hb = ref_hb(dw);
    if (off < dw) return ref_pos(off);
    if (off - dw < hb) return 1 << (off - dw);
    return 0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- drivers ----------------
  task automatic send_main(input logic [31:0] d, input logic [3:0] be, input logic [31:0] od);
    m_in_data = d; m_in_be = be; m_in_old = od; m_in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (m_in_ready) break;
    end
    @(posedge clk); #1;
    m_in_valid = 1'b0;
    main_beats++;
  endtask

  // returns edges counted from the accepting edge
  task automatic collect_main(output int lat);
    lat = 1;
    while (!m_out_valid) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic xfer_main(input logic [31:0] d, input logic [3:0] be, input logic [31:0] od,
                           output int lat, output logic [31:0] rd, output logic [15:0] rc);
    send_main(d, be, od);
    collect_main(lat);
    rd = m_out_data; rc = m_out_chk;
    @(posedge clk); #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R10", "out_valid after reset", 64'(m_out_valid), 64'd0);
    check("R10", "in_ready after reset", 64'(m_in_ready), 64'd1);
    check("R10", "burst_flag_valid after reset", 64'(m_flag_valid), 64'd0);
  endtask

  task automatic t_clean();
    logic [31:0] pats [5] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_8000, 32'hA5A5_3C3C, 32'h1234_FEDC};
    int lat; logic [31:0] rd; logic [15:0] rc; int sp;
    m_inj_mode = 2'd0;
    foreach (pats[p]) begin
      xfer_main(pats[p], 4'hF, 32'h0, lat, rd, rc);
      check("R7", "latency with merge stage", 64'(lat), 64'd2);
      check("R3", "data lanes", 64'(rd), 64'(pats[p]));
      for (int k = 0; k < 2; k++) begin
        check("R1", "check bits", 64'(rc[8*k +: 8]), 64'(ref_chk(64'(pats[p][16*k +: 16]), MDW)));
        check("R1", "clean syndrome", 64'(classify(64'(rd[16*k +: 16]), rc[8*k +: 8], MDW, sp)), 64'd0);
      end
      check("R2", "pad bits", 64'({rc[15:14], rc[7:6]}), 64'd0);
    end
  endtask

  task automatic run_inject(input logic [1:0] mode, input int a, input int b, input logic [31:0] d);
    int lat; logic [31:0] rd; logic [15:0] rc;
    m_inj_mode = mode; m_idx_a = 6'(a); m_idx_b = 6'(b);
    xfer_main(d, 4'hF, 32'h0, lat, rd, rc);
    for (int k = 0; k < 2; k++) begin
      int n = 0; int ep = 0; int sp; int cls;
      if ((mode == 2'd1 || mode == 2'd2) && a >= k*MCW && a < (k+1)*MCW) begin
        n++; ep = flip_pos(a - k*MCW, MDW);
      end
      if (mode == 2'd2 && b != a && b >= k*MCW && b < (k+1)*MCW) begin
        n++; ep = flip_pos(b - k*MCW, MDW);
      end
      cls = classify(64'(rd[16*k +: 16]), rc[8*k +: 8], MDW, sp);
      check("R4", $sformatf("class mode %0d idx %0d/%0d lane %0d", mode, a, b, k), 64'(cls), 64'(n));
      if (n == 1)
        check("R4", $sformatf("syndrome position idx %0d lane %0d", a, k), 64'(sp), 64'(ep));
    end
    m_inj_mode = 2'd0;
  endtask

  task automatic t_inject();
    run_inject(2'd1, 0, 30, 32'hDEAD_BEEF);    // data bit 0, lane 0
    run_inject(2'd1, 17, 3, 32'h0F0F_00FF);    // Hamming bit 1, lane 0
    run_inject(2'd1, 21, 3, 32'h1357_9BDF);    // overall parity, lane 0
    run_inject(2'd1, 27, 3, 32'hCAFE_0001);    // data bit 5, lane 1
    run_inject(2'd1, 43, 3, 32'h8000_0000);    // overall parity, lane 1
    run_inject(2'd2, 3, 9, 32'h5555_AAAA);     // double, lane 0
    run_inject(2'd2, 16, 2, 32'h0000_FFFF);    // check + data, lane 0
    run_inject(2'd2, 25, 40, 32'h7777_1111);   // double, lane 1
    run_inject(2'd2, 5, 30, 32'h2468_ACE0);    // one per lane
  endtask

  task automatic t_inject_edges();
    run_inject(2'd3, 4, 8, 32'h3C3C_C3C3);     // mode 3 = off
    run_inject(2'd1, 50, 3, 32'h9999_6666);    // out of range
    run_inject(2'd2, 63, 44, 32'h0102_0304);   // both out of range
    run_inject(2'd2, 7, 7, 32'hF00D_F00D);     // equal indices: one flip
  endtask

  task automatic t_merge();
    int lat; logic [31:0] rd; logic [15:0] rc; logic [31:0] exp;
    exp = 32'hAA11_BB22;
    xfer_main(32'h1111_2222, 4'b0101, 32'hAAAA_BBBB, lat, rd, rc);
    check("R6", "merged data be=0101", 64'(rd), 64'(exp));
    check("R6", "check lane 0 over merged", 64'(rc[7:0]), 64'(ref_chk(64'(exp[15:0]), MDW)));
    check("R6", "check lane 1 over merged", 64'(rc[15:8]), 64'(ref_chk(64'(exp[31:16]), MDW)));
    xfer_main(32'h1234_5678, 4'b0000, 32'h9ABC_DEF0, lat, rd, rc);
    check("R6", "be=0000 takes old data", 64'(rd), 64'h9ABC_DEF0);
    check("R7", "latency on merge path", 64'(lat), 64'd2);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    m_out_ready = 1'b0;
    send_main(32'h0BAD_F00D, 4'hF, 32'h0);
    send_main(32'h600D_CAFE, 4'hF, 32'h0);
    check("R8", "in_ready low when full and stalled", 64'(m_in_ready), 64'd0);
    check("R8", "first word presented", 64'(m_out_data), 64'h0BAD_F00D);
    held = m_out_data;
    repeat (3) begin @(posedge clk); #1; end
    check("R8", "out_valid held", 64'(m_out_valid), 64'd1);
    check("R8", "data held during stall", 64'(m_out_data), 64'(held));
    check("R8", "check lane held", 64'(m_out_chk[7:0]), 64'(ref_chk(64'(held[15:0]), MDW)));
    m_out_ready = 1'b1;
    @(posedge clk); #1;
    check("R7", "second word follows in order", 64'(m_out_data), 64'h600D_CAFE);
    check("R7", "second word check lane 1", 64'(m_out_chk[15:8]), 64'(ref_chk(64'h600D, MDW)));
    @(posedge clk); #1;
    check("R8", "pipeline empty after drain", 64'(m_out_valid), 64'd0);
    check("R8", "in_ready back high", 64'(m_in_ready), 64'd1);
  endtask

  task automatic run_burst(input logic [3:0] be2, input logic exp_flag);
    for (int i = 0; i < 4; i++) begin
      send_main(32'h1000_0000 + 32'(i), (i == 2) ? be2 : 4'hF, 32'h0);
      if (i < 3)
        check("R9", $sformatf("no flag after beat %0d", i+1), 64'(m_flag_valid), 64'd0);
    end
    check("R9", "flag pulse after 4th beat", 64'(m_flag_valid), 64'd1);
    check("R9", "rmw flag value", 64'(m_flag), 64'(exp_flag));
    @(posedge clk); #1;
    check("R9", "flag lasts one cycle", 64'(m_flag_valid), 64'd0);
  endtask

  task automatic t_burst();
    while (main_beats % 4 != 0) send_main(32'h0, 4'hF, 32'h0);
    repeat (3) begin @(posedge clk); #1; end
    run_burst(4'hF, 1'b0);
    run_burst(4'b1110, 1'b1);
    repeat (4) begin @(posedge clk); #1; end
  endtask

  task automatic t_lite();
    logic [7:0] pats [2] = '{8'h5A, 8'hC3};
    int lat; int sp;
    foreach (pats[p]) begin
      l_inj_mode = (p == 0) ? 2'd1 : 2'd2; l_idx_a = 4'd3; l_idx_b = 4'd9;
      l_in_data = pats[p]; l_in_be = 1'b0; l_in_old = 8'hFF; l_in_valid = 1'b1;
      forever begin @(negedge clk); if (l_in_ready) break; end
      @(posedge clk); #1;
      l_in_valid = 1'b0;
      lat = 1;
      while (!l_out_valid) begin @(posedge clk); #1; lat++; end
      check("R7", "latency without merge stage", 64'(lat), 64'd1);
      check("R6", "old data ignored without merge", 64'(l_out_data), 64'(pats[p]));
      check("R5", "no injection when removed", 64'(l_out_chk), 64'(ref_chk(64'(pats[p]), LDW)));
      check("R5", "clean syndrome when removed", 64'(classify(64'(l_out_data), l_out_chk, LDW, sp)), 64'd0);
      check("R2", "5-bit code pads lane", 64'(l_out_chk[7:5]), 64'd0);
      @(posedge clk); #1;
    end
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_clean();
    t_inject();
    t_inject_edges();
    t_merge();
    t_backpressure();
    t_burst();
    t_lite();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule